// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit performs the two double-width shift operations of a 32-bit integer datapath. A destination word is shifted left or right by a count of 0 to 31, and the vacated bit positions are filled from a second source word instead of with zeros. The count comes from one of two places, an immediate byte or a count register, and only its low five bits are used. Along with the shifted word the unit produces carry, overflow, zero, sign and parity flags, plus a write enable for the destination and one enable per flag, so the surrounding pipeline knows which architectural state to update.

Operand fetch, decode and writeback are handled elsewhere. A caller presents both operands, the direction, the count source and the two count candidates with a one-cycle `in_valid` strobe. One clock later the registered result, flags and enables appear with `out_valid`. When the masked count is zero, neither the destination nor any flag is written. Overflow is written only for a count of one. In every other case the enclosing flag register keeps its old overflow value.

Top module: `dshift_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `dst_we` and all bits of `flag_we` are 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` = 1. When strobes come back to back, each output cycle carries the result of its own strobe.
- R3: The effective count n is the low 5 bits of `imm_cnt` when `cnt_sel` = 0, and the low 5 bits of `cnt_reg` when `cnt_sel` = 1. The upper count bits and the unselected source have no effect.
- R4: When n = 0, `dst_we` = 0 and `flag_we` = 0 in the output cycle.
- R5: With `dir_right` = 0 and n ≠ 0, `result` = (dst << n) | (src >> (32 − n)).
- R6: With `dir_right` = 1 and n ≠ 0, `result` = (src << (32 − n)) | (dst >> n).
- R7: Carry (`flags[0]`) is destination bit 32 − n for a left shift and destination bit n − 1 for a right shift.
- R8: `flag_we[4]` (overflow) is 1 only when n = 1. In that case `flags[4]` is result bit 31 XOR the original destination bit 31.
- R9: Zero (`flags[2]`) is 1 exactly when `result` is 0. Sign (`flags[3]`) equals result bit 31.
- R10: Parity (`flags[1]`) is 1 when `result[7:0]` holds an even number of ones.
- R11: For any n ≠ 0, `dst_we` = 1 and `flag_we[3:0]` = 4'b1111. The flag bit order is {OF, SF, ZF, PF, CF}, from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| cnt_sel | input | 1 | 0 = immediate count, 1 = count register |
| imm_cnt | input | 8 | Immediate count byte |
| cnt_reg | input | 8 | Count register low byte |
| dst_op | input | 32 | Destination operand |
| src_op | input | 32 | Fill operand |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Shifted word |
| dst_we | output | 1 | Destination write enable |
| flags | output | 5 | {OF, SF, ZF, PF, CF} values |
| flag_we | output | 5 | Per-flag write enables, same order |

## Verification
The hardest situation to reach is a count of zero whose raw source byte is not zero. This needs upper count bits set while the low five bits are clear, with the other count source holding a nonzero value at the same time. The directed stimulus builds exactly that pairing for both sources, then does the reverse: a selected byte with a count of one, next to an unselected source that would give a zero count. The overflow enable gets the same treatment around n = 1. Full sweeps of all 32 counts in each direction, using each source, cover the carry bit positions at both extremes.

// File: rtl/dsh_pkg.sv
// Shared sizes and flag bit positions for the double shift unit.
// Assumes a datapath width that is a power of two.
package dsh_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = $clog2(DATA_W);
    localparam int unsigned CSRC_W = 8;
    localparam int unsigned NFLAG  = 5;
    localparam int unsigned PAR_W  = 8;
    // flag vector positions
    localparam int unsigned FLG_CF = 0;
    localparam int unsigned FLG_PF = 1;
    localparam int unsigned FLG_ZF = 2;
    localparam int unsigned FLG_SF = 3;
    localparam int unsigned FLG_OF = 4;
endpackage

// File: rtl/dsh_count_sel.sv
// Count source selection and masking.
// Picks the immediate or register count, keeps its low CNT_W bits,
// and flags the zero and one cases that gate the write enables.
module dsh_count_sel #(
    parameter int unsigned CSRC_W = dsh_pkg::CSRC_W,
    parameter int unsigned CNT_W  = dsh_pkg::CNT_W
) (
    input  logic              sel_reg,
    input  logic [CSRC_W-1:0] imm_raw,
    input  logic [CSRC_W-1:0] reg_raw,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero,
    output logic              cnt_one
);
    logic [CSRC_W-1:0] raw_pick;

    // choose the source and truncate to the effective count
    always_comb begin
        raw_pick = sel_reg ? reg_raw : imm_raw;
        cnt      = CNT_W'(raw_pick);
        cnt_zero = (cnt == '0);
        cnt_one  = (cnt == CNT_W'(1));
    end
endmodule

// File: rtl/dsh_funnel.sv
// Funnel shifter core.
// Concatenates destination and fill words with one guard bit and shifts
// the wide word, so the result and the last bit shifted out come from
// one shifter per direction. Assumes cnt < DATA_W.
module dsh_funnel #(
    parameter int unsigned DATA_W = dsh_pkg::DATA_W,
    parameter int unsigned CNT_W  = dsh_pkg::CNT_W
) (
    input  logic              dir_right,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] res,
    output logic              carry
);
    localparam int unsigned WIDE_W = 2 * DATA_W + 1;

    logic [WIDE_W-1:0] lft_w;
    logic [WIDE_W-1:0] rgt_w;
    logic [DATA_W-1:0] lft_res;
    logic [DATA_W-1:0] rgt_res;

    // left: guard above dst; dst in upper half receives src bits
    always_comb begin
        lft_w   = {1'b0, dst, src} << cnt;
        lft_res = DATA_W'(lft_w >> DATA_W);
    end

    // right: guard below dst; src above dst fills vacated msbs
    always_comb begin
        rgt_w   = {src, dst, 1'b0} >> cnt;
        rgt_res = DATA_W'(rgt_w >> 1);
    end

    // pick the direction requested
    always_comb begin
        res   = dir_right ? rgt_res : lft_res;
        carry = dir_right ? rgt_w[0] : lft_w[WIDE_W-1];
    end
endmodule

// File: rtl/dsh_flag_gen.sv
// Status flag generation from the shifted word.
// Produces {OF, SF, ZF, PF, CF}; overflow assumes a count of one and is
// only meaningful when its enable is raised by the caller.
module dsh_flag_gen #(
    parameter int unsigned DATA_W = dsh_pkg::DATA_W,
    parameter int unsigned NFLAG  = dsh_pkg::NFLAG,
    parameter int unsigned PAR_W  = dsh_pkg::PAR_W
) (
    input  logic [DATA_W-1:0] res,
    input  logic              dst_msb,
    input  logic              carry,
    output logic [NFLAG-1:0]  flg
);
    // assemble each flag in its fixed position
    always_comb begin
        flg                 = '0;
        flg[dsh_pkg::FLG_CF] = carry;
        flg[dsh_pkg::FLG_PF] = ~^res[PAR_W-1:0];
        flg[dsh_pkg::FLG_ZF] = (res == '0);
        flg[dsh_pkg::FLG_SF] = res[DATA_W-1];
        flg[dsh_pkg::FLG_OF] = res[DATA_W-1] ^ dst_msb;
    end
endmodule

// File: rtl/dshift_unit.sv
// Double-precision shift unit top.
// Selects the count, funnel-shifts dst with src fill, derives flags and
// registers everything one cycle after in_valid. Zero counts suppress
// all writes; overflow is written only for a count of one.
module dshift_unit #(
    parameter int unsigned DATA_W = dsh_pkg::DATA_W,
    parameter int unsigned CSRC_W = dsh_pkg::CSRC_W,
    parameter int unsigned NFLAG  = dsh_pkg::NFLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir_right,
    input  logic              cnt_sel,
    input  logic [CSRC_W-1:0] imm_cnt,
    input  logic [CSRC_W-1:0] cnt_reg,
    input  logic [DATA_W-1:0] dst_op,
    input  logic [DATA_W-1:0] src_op,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              dst_we,
    output logic [NFLAG-1:0]  flags,
    output logic [NFLAG-1:0]  flag_we
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  cnt_eff;
    logic              cnt_zero;
    logic              cnt_one;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [NFLAG-1:0]  flg_nxt;
    logic [NFLAG-1:0]  we_nxt;
    logic              do_write;

    dsh_count_sel #(.CSRC_W(CSRC_W), .CNT_W(CNT_W)) u_cnt (
        .sel_reg  (cnt_sel),
        .imm_raw  (imm_cnt),
        .reg_raw  (cnt_reg),
        .cnt      (cnt_eff),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    dsh_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fun (
        .dir_right (dir_right),
        .dst       (dst_op),
        .src       (src_op),
        .cnt       (cnt_eff),
        .res       (sh_res),
        .carry     (sh_carry)
    );

    dsh_flag_gen #(.DATA_W(DATA_W), .NFLAG(NFLAG)) u_flg (
        .res     (sh_res),
        .dst_msb (dst_op[DATA_W-1]),
        .carry   (sh_carry),
        .flg     (flg_nxt)
    );

    // enables: all but overflow on any nonzero count, overflow on one
    always_comb begin
        do_write = in_valid & ~cnt_zero;
        we_nxt   = {cnt_one, {(NFLAG-1){1'b1}}} & {NFLAG{do_write}};
    end

    // output stage: one cycle latency, data held between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_we    <= 1'b0;
            flag_we   <= '0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            dst_we    <= do_write;
            flag_we   <= we_nxt;
            if (in_valid) begin
                result <= sh_res;
                flags  <= flg_nxt;
            end
        end
    end
endmodule

// File: rtl/dsh_checker.sv
// Protocol and flag checks for dshift_unit, attached by bind.
module dsh_checker #(
    parameter int unsigned DATA_W = dsh_pkg::DATA_W,
    parameter int unsigned CSRC_W = dsh_pkg::CSRC_W,
    parameter int unsigned NFLAG  = dsh_pkg::NFLAG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              cnt_sel,
    input logic [CSRC_W-1:0] imm_cnt,
    input logic [CSRC_W-1:0] cnt_reg,
    input logic              dst_msb,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              dst_we,
    input logic              of_bit,
    input logic              sf_bit,
    input logic              zf_bit,
    input logic              pf_bit,
    input logic [NFLAG-1:0]  flag_we
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    logic [CNT_W-1:0] chk_n;
    assign chk_n = CNT_W'(cnt_sel ? cnt_reg : imm_cnt);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    zero_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_n == '0) |=> (!dst_we && flag_we == '0));
    // R8
    of_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_n != CNT_W'(1)) |=> !flag_we[NFLAG-1]);
    // R8
    of_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we[NFLAG-1] |-> (of_bit == (result[DATA_W-1] ^ $past(dst_msb))));
    // R9
    sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (sf_bit == result[DATA_W-1] && zf_bit == (result == '0)));
    // R10
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (pf_bit == ~^result[7:0]));
    // R11
    we_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (out_valid && flag_we[NFLAG-2:0] == '1));
endmodule

bind dshift_unit dsh_checker #(.DATA_W(DATA_W), .CSRC_W(CSRC_W), .NFLAG(NFLAG)) u_dsh_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cnt_sel   (cnt_sel),
    .imm_cnt   (imm_cnt),
    .cnt_reg   (cnt_reg),
    .dst_msb   (dst_op[DATA_W-1]),
    .out_valid (out_valid),
    .result    (result),
    .dst_we    (dst_we),
    .of_bit    (flags[4]),
    .sf_bit    (flags[3]),
    .zf_bit    (flags[2]),
    .pf_bit    (flags[1]),
    .flag_we   (flag_we)
);

// File: tb/test_dshift_unit.sv
module test_dshift_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        dir_right;
    logic        cnt_sel;
    logic [7:0]  imm_cnt;
    logic [7:0]  cnt_reg;
    logic [31:0] dst_op;
    logic [31:0] src_op;
    logic        out_valid;
    logic [31:0] result;
    logic        dst_we;
    logic [4:0]  flags;
    logic [4:0]  flag_we;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dshift_unit i_dshift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_right(dir_right),
        .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .cnt_reg(cnt_reg),
        .dst_op(dst_op), .src_op(src_op), .out_valid(out_valid),
        .result(result), .dst_we(dst_we), .flags(flags), .flag_we(flag_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bitwise reference built from the requirement equations
    task automatic ref_op(input bit rgt, input logic [31:0] d, input logic [31:0] s,
                          input int n, output logic [31:0] r, output logic cf);
        for (int j = 0; j < 32; j++) begin
            int k;
            if (!rgt) begin
                k = j - n;
                r[j] = (k >= 0) ? d[k] : s[32 + k];
            end else begin
                k = j + n;
                r[j] = (k < 32) ? d[k] : s[k - 32];
            end
        end
        cf = rgt ? d[n - 1] : d[32 - n];
    endtask

    task automatic check_out(input bit rgt, input bit sel, input logic [7:0] ic,
                             input logic [7:0] rc, input logic [31:0] d, input logic [31:0] s);
        int n;
        logic [31:0] er;
        logic ecf;
        int ones;
        n = int'((sel ? rc : ic) & 8'h1f);
        chk(out_valid === 1'b1, "R2 out_valid", {31'd0, out_valid}, 32'd1);
        if (n == 0) begin
            chk(dst_we === 1'b0, "R4 dst_we", {31'd0, dst_we}, 32'd0);
            chk(flag_we === 5'd0, "R4 flag_we", {27'd0, flag_we}, 32'd0);
        end else begin
            ref_op(rgt, d, s, n, er, ecf);
            chk(result === er, rgt ? "R6 result" : "R5 result", result, er);
            chk(dst_we === 1'b1 && flag_we[3:0] === 4'hf, "R11 enables",
                {27'd0, flag_we}, 32'h0f);
            chk(flags[0] === ecf, "R7 carry", {31'd0, flags[0]}, {31'd0, ecf});
            chk(flag_we[4] === (n == 1), "R8 of enable", {31'd0, flag_we[4]}, (n == 1) ? 32'd1 : 32'd0);
            if (n == 1)
                chk(flags[4] === (er[31] ^ d[31]), "R8 of value", {31'd0, flags[4]}, {31'd0, er[31] ^ d[31]});
            chk(flags[2] === (er == 0), "R9 zero", {31'd0, flags[2]}, (er == 0) ? 32'd1 : 32'd0);
            chk(flags[3] === er[31], "R9 sign", {31'd0, flags[3]}, {31'd0, er[31]});
            ones = $countones(er[7:0]);
            chk(flags[1] === (ones % 2 == 0), "R10 parity", {31'd0, flags[1]}, (ones % 2 == 0) ? 32'd1 : 32'd0);
        end
    endtask

    task automatic do_op(input bit rgt, input bit sel, input logic [7:0] ic,
                         input logic [7:0] rc, input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        in_valid = 1'b1; dir_right = rgt; cnt_sel = sel;
        imm_cnt = ic; cnt_reg = rc; dst_op = d; src_op = s;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(rgt, sel, ic, rc, d, s);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; dir_right = 1'b0; cnt_sel = 1'b0;
        imm_cnt = 8'd3; cnt_reg = 8'd0; dst_op = '1; src_op = '1;
        repeat (3) @(negedge clk);
        // R1 reset state even with a strobe held high
        chk(out_valid === 1'b0 && dst_we === 1'b0 && flag_we === 5'd0, "R1 reset",
            {26'd0, out_valid, flag_we}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 idle after reset", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_left_sweep;
        for (int n = 0; n < 32; n++)
            do_op(1'b0, 1'b0, 8'(n), 8'($urandom), $urandom, $urandom); // R5 R3 immediate
    endtask

    task automatic t_right_sweep;
        for (int n = 0; n < 32; n++)
            do_op(1'b1, 1'b1, 8'($urandom), 8'(n), $urandom, $urandom); // R6 R3 register
    endtask

    task automatic t_count_mask;
        // R3: upper bits dropped, unselected source ignored
        do_op(1'b0, 1'b0, 8'he3, 8'h41, 32'h8765_4321, 32'hfedc_ba98);
        do_op(1'b1, 1'b1, 8'h20, 8'ha1, 32'h1234_5678, 32'h9abc_def0);
        do_op(1'b1, 1'b0, 8'h7f, 8'h00, 32'h8000_0001, 32'h0000_0003);
    endtask

    task automatic t_zero_count;
        // R4: zero masked count with nonzero upper bits / other source
        do_op(1'b0, 1'b0, 8'h60, 8'h05, 32'hdead_beef, 32'h1111_1111);
        do_op(1'b1, 1'b1, 8'h07, 8'he0, 32'hdead_beef, 32'h2222_2222);
    endtask

    task automatic t_overflow;
        // R8: sign change and no sign change at n = 1, both directions
        do_op(1'b0, 1'b0, 8'd1, 8'd0, 32'h4000_0000, 32'h0);
        do_op(1'b0, 1'b0, 8'd1, 8'd0, 32'hc000_0000, 32'h0);
        do_op(1'b1, 1'b0, 8'd1, 8'd0, 32'h0000_0002, 32'h0000_0001);
        do_op(1'b1, 1'b1, 8'd0, 8'd1, 32'h8000_0000, 32'h0000_0001);
        do_op(1'b0, 1'b0, 8'd2, 8'd1, 32'h4000_0000, 32'h0);
    endtask

    task automatic t_zero_parity;
        // R9 R10: zero result, odd and even parity bytes
        do_op(1'b0, 1'b0, 8'd5, 8'd0, 32'h0, 32'h0);
        do_op(1'b1, 1'b0, 8'd8, 8'd0, 32'h0000_0700, 32'h0);
        do_op(1'b1, 1'b0, 8'd8, 8'd0, 32'h0000_0300, 32'h0);
        do_op(1'b0, 1'b0, 8'd31, 8'd0, 32'h0000_0001, 32'hffff_fffe);
    endtask

    task automatic t_back_to_back;
        logic [31:0] ea, eb;
        logic ca, cb;
        ref_op(1'b0, 32'h0f0f_0f0f, 32'hf000_0000, 4, ea, ca);
        ref_op(1'b1, 32'h1357_9bdf, 32'h2468_ace0, 12, eb, cb);
        @(negedge clk);
        in_valid = 1'b1; dir_right = 1'b0; cnt_sel = 1'b0; imm_cnt = 8'd4;
        dst_op = 32'h0f0f_0f0f; src_op = 32'hf000_0000;
        @(negedge clk);
        dir_right = 1'b1; cnt_sel = 1'b1; cnt_reg = 8'd12; imm_cnt = 8'd0;
        dst_op = 32'h1357_9bdf; src_op = 32'h2468_ace0;
        chk(out_valid === 1'b1 && result === ea, "R2 first of pair", result, ea);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && result === eb, "R2 second of pair", result, eb);
        @(negedge clk);
        chk(out_valid === 1'b0 && dst_we === 1'b0, "R2 valid drops", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_left_sweep();
        t_right_sweep();
        t_count_mask();
        t_zero_count();
        t_overflow();
        t_zero_parity();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule